// File: doc/BRIEF.md
# Floating-Point Compare Unit

This unit takes two binary floating-point words and, one clock later, reports how they are ordered. It returns four flags: less, equal, greater and unordered. It also returns the smaller and the larger operand as whole words, and for each operand a class code and its sign. Two parameters size the exponent and fraction fields. The defaults give the 32-bit format; an 11-bit exponent with a 52-bit fraction gives the 64-bit format.

Ordering starts from the raw bit patterns. With the sign removed, the rest of each word is compared as an unsigned integer. That result is then corrected in four ways:

- the sign bits decide the order when they differ;
- the order is reversed when both operands are negative;
- the two zeros are made equal;
- any NaN operand gives an unordered result.

The unit is a single register stage with no back-pressure. It accepts a pair on every cycle in which `in_valid` is high, so it is always ready. `out_valid` follows one cycle later, and the result is held until the next accepted pair. A consumer that cannot take a result in the cycle it appears must latch it.

Top module: `fpcmp_unit`

## Requirements
- R1: An operand word has the sign in the top bit (1 = negative), then an EXP_W-bit biased exponent, then an FRAC_W-bit fraction in the low bits. Each operand is classified with a 3-bit code:
  - 0 = zero (exponent 0, fraction 0);
  - 1 = denormal (exponent 0, fraction nonzero);
  - 2 = normal;
  - 3 = infinity (exponent all ones, fraction 0);
  - 4 = NaN (exponent all ones, fraction nonzero).
- R2: A pair presented with `in_valid` high is captured at that rising edge, and its results appear with `out_valid` high exactly one cycle later. `out_valid` is low in every cycle that follows a cycle with `in_valid` low.
- R3: A synchronous active-high `rst` clears `out_valid` and all four flags.
- R4: While `out_valid` is high, exactly one of `lt`, `eq`, `gt`, `unord` is high.
- R5: If either operand is a NaN, whatever its sign, `unord` is high and `lt`, `eq` and `gt` are low.
- R6: Any two zeros compare equal, whatever their signs.
- R7: When the sign bits differ and the operands are not both zero, the negative operand is the lesser. An infinity orders beyond every finite value of the same sign.
- R8: When both operands are non-negative, the order is the unsigned integer order of the bits below the sign. This makes denormals order correctly against normals.
- R9: When both operands are negative, the order is the reverse of the unsigned integer order of the bits below the sign.
- R10: For an ordered pair, `min_out` returns the lesser operand and `max_out` the greater. For equal operands both return operand A, except for two zeros of different sign, where `min_out` is the negative zero and `max_out` the positive zero.
- R11: When the pair is unordered, `min_out` and `max_out` both return the first NaN operand unchanged: operand A if it is a NaN, otherwise operand B.
- R12: `a_sign` and `b_sign` return the sign bits of the captured operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand pair present; captured this edge |
| a_in | input | 1+EXP_W+FRAC_W | Operand A |
| b_in | input | 1+EXP_W+FRAC_W | Operand B |
| out_valid | output | 1 | Results valid (one cycle after capture) |
| lt | output | 1 | A is less than B |
| eq | output | 1 | A equals B |
| gt | output | 1 | A is greater than B |
| unord | output | 1 | At least one operand is a NaN |
| min_out | output | 1+EXP_W+FRAC_W | Lesser operand, or the first NaN |
| max_out | output | 1+EXP_W+FRAC_W | Greater operand, or the first NaN |
| a_class | output | 3 | Class code of operand A |
| b_class | output | 3 | Class code of operand B |
| a_sign | output | 1 | Sign bit of operand A |
| b_sign | output | 1 | Sign bit of operand B |

## Verification
Every pairing of a fixed set of corner words is applied. The set covers:

- both zeros;
- both infinities;
- the smallest and largest denormal and normal magnitudes of each sign;
- NaNs of both signs.

These pairs separate the zero-equality correction, the sign-split rule, the reversal for two negatives, and the choice of which NaN is passed through. Random pairs, biased towards zero and all-ones exponents, then exercise the integer ordering across field boundaries. Short directed sequences check back-to-back capture, the idle cycle in which `out_valid` drops, and a reset that clears a pending result.

// File: rtl/fpcmp_pkg.sv
package fpcmp_pkg;

  typedef enum logic [2:0] {
    CLS_ZERO   = 3'd0,
    CLS_DENORM = 3'd1,
    CLS_NORMAL = 3'd2,
    CLS_INF    = 3'd3,
    CLS_NAN    = 3'd4
  } fp_class_e;

  typedef enum logic [1:0] {
    ORD_LT = 2'd0,
    ORD_EQ = 2'd1,
    ORD_GT = 2'd2,
    ORD_UN = 2'd3
  } fp_order_e;

endpackage

// File: rtl/fpcmp_classify.sv
module fpcmp_classify
  import fpcmp_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int W     = 1 + EXP_W + FRAC_W
) (
  input  logic [W-1:0] word,
  output fp_class_e    cls,
  output logic         neg,
  output logic [W-2:0] mag
);

  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;
  logic              exp_zero, exp_ones, frac_zero;

  assign exp_f     = word[W-2 -: EXP_W];
  assign frac_f    = word[FRAC_W-1:0];
  assign neg       = word[W-1];
  assign mag       = word[W-2:0];
  assign exp_zero  = (exp_f == '0);
  assign exp_ones  = &exp_f;
  assign frac_zero = (frac_f == '0);

  always_comb begin
    if (exp_zero)      cls = frac_zero ? CLS_ZERO : CLS_DENORM;
    else if (exp_ones) cls = frac_zero ? CLS_INF  : CLS_NAN;
    else               cls = CLS_NORMAL;
  end

endmodule

// File: rtl/fpcmp_order.sv
module fpcmp_order
  import fpcmp_pkg::*;
#(
  parameter int MAG_W = 31
) (
  input  fp_class_e        a_cls,
  input  fp_class_e        b_cls,
  input  logic             a_neg,
  input  logic             b_neg,
  input  logic [MAG_W-1:0] a_mag,
  input  logic [MAG_W-1:0] b_mag,
  output fp_order_e        ord
);

  logic mag_lt, mag_eq;

  assign mag_lt = (a_mag < b_mag);
  assign mag_eq = (a_mag == b_mag);

  always_comb begin
    if (a_cls == CLS_NAN || b_cls == CLS_NAN)
      ord = ORD_UN;
    else if (a_cls == CLS_ZERO && b_cls == CLS_ZERO)
      ord = ORD_EQ;
    else if (a_neg != b_neg)
      ord = a_neg ? ORD_LT : ORD_GT;
    else if (mag_eq)
      ord = ORD_EQ;
    else if (mag_lt ^ a_neg)
      ord = ORD_LT;
    else
      ord = ORD_GT;
  end

endmodule

// File: rtl/fpcmp_select.sv
module fpcmp_select
  import fpcmp_pkg::*;
#(
  parameter int W = 32
) (
  input  fp_order_e    ord,
  input  fp_class_e    a_cls,
  input  logic [W-1:0] a_word,
  input  logic [W-1:0] b_word,
  output logic [W-1:0] lo_word,
  output logic [W-1:0] hi_word
);

  logic a_neg, b_neg, split_zero;

  assign a_neg      = a_word[W-1];
  assign b_neg      = b_word[W-1];
  assign split_zero = (a_cls == CLS_ZERO) && (a_neg != b_neg);

  always_comb begin
    unique case (ord)
      ORD_LT: begin
        lo_word = a_word;
        hi_word = b_word;
      end
      ORD_GT: begin
        lo_word = b_word;
        hi_word = a_word;
      end
      ORD_EQ: begin
        if (split_zero) begin
          lo_word = a_neg ? a_word : b_word;
          hi_word = a_neg ? b_word : a_word;
        end else begin
          lo_word = a_word;
          hi_word = a_word;
        end
      end
      default: begin
        lo_word = (a_cls == CLS_NAN) ? a_word : b_word;
        hi_word = lo_word;
      end
    endcase
  end

endmodule

// File: rtl/fpcmp_unit.sv
module fpcmp_unit
  import fpcmp_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int W     = 1 + EXP_W + FRAC_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  output logic         out_valid,
  output logic         lt,
  output logic         eq,
  output logic         gt,
  output logic         unord,
  output logic [W-1:0] min_out,
  output logic [W-1:0] max_out,
  output logic [2:0]   a_class,
  output logic [2:0]   b_class,
  output logic         a_sign,
  output logic         b_sign
);

  localparam int NOPS  = 2;
  localparam int MAG_W = W - 1;

  logic [W-1:0]     words [NOPS];
  fp_class_e        cls   [NOPS];
  logic             neg   [NOPS];
  logic [MAG_W-1:0] mag   [NOPS];

  assign words[0] = a_in;
  assign words[1] = b_in;

  for (genvar i = 0; i < NOPS; i++) begin : g_cls
    fpcmp_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
      .word (words[i]),
      .cls  (cls[i]),
      .neg  (neg[i]),
      .mag  (mag[i])
    );
  end

  fp_order_e    ord;
  logic [W-1:0] lo_word, hi_word;

  fpcmp_order #(.MAG_W(MAG_W)) u_ord (
    .a_cls (cls[0]),
    .b_cls (cls[1]),
    .a_neg (neg[0]),
    .b_neg (neg[1]),
    .a_mag (mag[0]),
    .b_mag (mag[1]),
    .ord   (ord)
  );

  fpcmp_select #(.W(W)) u_sel (
    .ord     (ord),
    .a_cls   (cls[0]),
    .a_word  (a_in),
    .b_word  (b_in),
    .lo_word (lo_word),
    .hi_word (hi_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      lt        <= 1'b0;
      eq        <= 1'b0;
      gt        <= 1'b0;
      unord     <= 1'b0;
      min_out   <= '0;
      max_out   <= '0;
      a_class   <= '0;
      b_class   <= '0;
      a_sign    <= 1'b0;
      b_sign    <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        lt      <= (ord == ORD_LT);
        eq      <= (ord == ORD_EQ);
        gt      <= (ord == ORD_GT);
        unord   <= (ord == ORD_UN);
        min_out <= lo_word;
        max_out <= hi_word;
        a_class <= cls[0];
        b_class <= cls[1];
        a_sign  <= neg[0];
        b_sign  <= neg[1];
      end
    end
  end

endmodule

// File: rtl/fpcmp_unit_chk.sv
module fpcmp_unit_chk #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int W     = 1 + EXP_W + FRAC_W
) (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic [W-1:0] a_in,
  input logic [W-1:0] b_in,
  input logic         out_valid,
  input logic         lt,
  input logic         eq,
  input logic         gt,
  input logic         unord,
  input logic [W-1:0] min_out,
  input logic [W-1:0] max_out
);

  logic a_nan, b_nan, a_zero, b_zero;

  assign a_nan  = (&a_in[W-2 -: EXP_W]) && (a_in[FRAC_W-1:0] != '0);
  assign b_nan  = (&b_in[W-2 -: EXP_W]) && (b_in[FRAC_W-1:0] != '0);
  assign a_zero = (a_in[W-2:0] == '0);
  assign b_zero = (b_in[W-2:0] == '0);

  AST_LATENCY_HIGH: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R2
  AST_LATENCY_LOW: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid); // R2
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> !out_valid && !lt && !eq && !gt && !unord); // R3
  AST_ONE_FLAG: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $countones({lt, eq, gt, unord}) == 1); // R4
  AST_NAN_UNORDERED: assert property (@(posedge clk) disable iff (rst)
    in_valid && (a_nan || b_nan) |=> unord); // R5
  AST_ZEROS_EQUAL: assert property (@(posedge clk) disable iff (rst)
    in_valid && a_zero && b_zero |=> eq); // R6
  AST_SIGN_SPLIT: assert property (@(posedge clk) disable iff (rst)
    in_valid && !a_nan && !b_nan && !(a_zero && b_zero) && (a_in[W-1] != b_in[W-1])
    |=> ($past(a_in[W-1]) ? lt : gt)); // R7
  AST_MIN_MAX_LT: assert property (@(posedge clk) disable iff (rst)
    out_valid && lt |-> (min_out == $past(a_in)) && (max_out == $past(b_in))); // R10
  AST_NAN_PASS: assert property (@(posedge clk) disable iff (rst)
    out_valid && unord |-> (min_out == max_out)); // R11

endmodule

bind fpcmp_unit fpcmp_unit_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .a_in      (a_in),
  .b_in      (b_in),
  .out_valid (out_valid),
  .lt        (lt),
  .eq        (eq),
  .gt        (gt),
  .unord     (unord),
  .min_out   (min_out),
  .max_out   (max_out)
);

// File: tb/sim_fpcmp_unit.sv
`timescale 1ns/1ps
module sim_fpcmp_unit;

  localparam int EXP_W  = 8;
  localparam int FRAC_W = 23;
  localparam int W      = 1 + EXP_W + FRAC_W;
  localparam int NCORN  = 14;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic         out_valid, lt, eq, gt, unord, a_sign, b_sign;
  logic [W-1:0] min_out, max_out;
  logic [2:0]   a_class, b_class;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  fpcmp_unit #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .a_in(a_in), .b_in(b_in),
    .out_valid(out_valid), .lt(lt), .eq(eq), .gt(gt), .unord(unord),
    .min_out(min_out), .max_out(max_out), .a_class(a_class), .b_class(b_class),
    .a_sign(a_sign), .b_sign(b_sign)
  );

  function automatic logic [W-1:0] mk(input bit s, input logic [EXP_W-1:0] e,
                                      input logic [FRAC_W-1:0] f);
    return {s, e, f};
  endfunction

  // R1: expected class code from the fields
  function automatic logic [2:0] ref_cls(input logic [W-1:0] x);
    logic [EXP_W-1:0]  e = x[W-2 -: EXP_W];
    logic [FRAC_W-1:0] f = x[FRAC_W-1:0];
    if (e == 0)  return (f == 0) ? 3'd0 : 3'd1;
    if (&e)      return (f == 0) ? 3'd3 : 3'd4;
    return 3'd2;
  endfunction

  function automatic longint key(input logic [W-1:0] x);
    longint m = longint'(x[W-2:0]);
    return x[W-1] ? -m : m;
  endfunction

  // expected flags {lt,eq,gt,unord}
  function automatic logic [3:0] ref_flags(input logic [W-1:0] a, input logic [W-1:0] b);
    longint ka, kb;
    if (ref_cls(a) == 4 || ref_cls(b) == 4) return 4'b0001;
    ka = key(a);
    kb = key(b);
    if (ka < kb) return 4'b1000;
    if (ka > kb) return 4'b0010;
    return 4'b0100;
  endfunction

  function automatic string tag_of(input logic [W-1:0] a, input logic [W-1:0] b);
    if (ref_cls(a) == 4 || ref_cls(b) == 4) return "R5/R11";
    if (ref_cls(a) == 0 && ref_cls(b) == 0) return "R6/R10";
    if (a[W-1] != b[W-1]) return "R7/R10";
    if (!a[W-1]) return "R8/R10";
    return "R9/R10";
  endfunction

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp_v);
    n_chk++;
    if (act !== exp_v) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp_v);
    end
  endtask

  task automatic check_result(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [3:0]   fl = ref_flags(a, b);
    logic [W-1:0] lo, hi;
    string        t  = tag_of(a, b);
    if (fl[0]) begin
      lo = (ref_cls(a) == 4) ? a : b;
      hi = lo;
    end else if (fl[3]) begin
      lo = a; hi = b;
    end else if (fl[1]) begin
      lo = b; hi = a;
    end else if (a[W-1] != b[W-1]) begin
      lo = a[W-1] ? a : b;
      hi = a[W-1] ? b : a;
    end else begin
      lo = a; hi = a;
    end
    chk("R2 out_valid", W'(out_valid), W'(1));
    chk({t, " R4 flags"}, W'({lt, eq, gt, unord}), W'(fl));
    chk({t, " min"}, min_out, lo);
    chk({t, " max"}, max_out, hi);
    chk("R1 a_class", W'(a_class), W'(ref_cls(a)));
    chk("R1 b_class", W'(b_class), W'(ref_cls(b)));
    chk("R12 signs", W'({a_sign, b_sign}), W'({a[W-1], b[W-1]}));
  endtask

  task automatic run_pair(input logic [W-1:0] a, input logic [W-1:0] b);
    @(negedge clk);
    a_in = a; b_in = b; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check_result(a, b);
  endtask

  function automatic logic [W-1:0] rand_word();
    logic [EXP_W-1:0]  e;
    logic [FRAC_W-1:0] f;
    int sel = $urandom_range(0, 5);
    f = FRAC_W'({$urandom, $urandom});
    if (sel == 0)      e = '0;
    else if (sel == 1) e = '1;
    else               e = EXP_W'($urandom);
    if ($urandom_range(0, 7) == 0) f = '0;
    return {1'($urandom), e, f};
  endfunction

  logic [W-1:0] corn [NCORN];

  initial begin
    void'($urandom(32'd20240611));
    corn[0]  = mk(0, '0, '0);                   // +0
    corn[1]  = mk(1, '0, '0);                   // -0
    corn[2]  = mk(0, '1, '0);                   // +inf
    corn[3]  = mk(1, '1, '0);                   // -inf
    corn[4]  = mk(0, '0, FRAC_W'(1));           // min denormal
    corn[5]  = mk(0, '0, '1);                   // max denormal
    corn[6]  = mk(0, EXP_W'(1), '0);            // min normal
    corn[7]  = mk(0, ~EXP_W'(1), '1);           // max normal
    corn[8]  = mk(0, '1, FRAC_W'(5));           // +NaN
    corn[9]  = mk(1, '1, '1);                   // -NaN
    corn[10] = mk(1, '0, FRAC_W'(1));
    corn[11] = mk(1, '0, '1);
    corn[12] = mk(1, EXP_W'(1), '0);
    corn[13] = mk(1, ~EXP_W'(1), '1);

    // R3: reset state
    repeat (3) @(negedge clk);
    chk("R3 reset out_valid", W'(out_valid), W'(0));
    chk("R3 reset flags", W'({lt, eq, gt, unord}), W'(0));
    @(negedge clk); rst = 1'b0;

    // corner pairs: every ordering of the corner set
    for (int i = 0; i < NCORN; i++)
      for (int j = 0; j < NCORN; j++)
        run_pair(corn[i], corn[j]);

    // R2: idle cycle drops out_valid
    @(negedge clk);
    chk("R2 idle out_valid", W'(out_valid), W'(0));

    // R2: back-to-back capture
    @(negedge clk);
    a_in = corn[6]; b_in = corn[7]; in_valid = 1'b1;
    @(negedge clk);
    check_result(corn[6], corn[7]);
    a_in = corn[13]; b_in = corn[12];
    @(negedge clk);
    in_valid = 1'b0;
    check_result(corn[13], corn[12]);

    // random pairs
    for (int k = 0; k < 600; k++) begin
      logic [W-1:0] ra = rand_word();
      logic [W-1:0] rb = ($urandom_range(0, 9) == 0) ? ra : rand_word();
      run_pair(ra, rb);
    end

    // R3: reset clears a pending result
    @(negedge clk);
    a_in = corn[8]; b_in = corn[0]; in_valid = 1'b1; rst = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R3 mid reset out_valid", W'(out_valid), W'(0));
    chk("R3 mid reset flags", W'({lt, eq, gt, unord}), W'(0));
    rst = 1'b0;

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

endmodule